// File: doc/BRIEF.md
# Supply Supervisor Watchdog and Reset Generator

This block is the digital control section of a processor supply supervisor. It watches two comparator flags, one for the main supply and one for a backup supply. It also runs a watchdog that software must service, and it produces the processor reset from these sources. Every timing decision is made on pulses from an external millisecond timebase. The comparators and the oscillator sit outside the block.

When the main supply drops, or when the watchdog is not serviced within the selected period, the block asserts reset. Reset then stays asserted for a fixed number of timebase ticks after the cause has gone. A two-bit flag that software can read holds the cause of the most recent reset. A separate output blocks memory access while the main supply is low. The backup-supply failure output follows its own flag and has no effect on reset.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_rst_o` is 1, `cause_o` is 00, and `v2fail_o` and `mem_block_o` are 0. After `rst_n` rises, `cpu_rst_o` stays 1 until HOLD_TICKS timebase ticks have been seen, and then drops to 0.
- R2: With the watchdog enabled and not serviced, reset asserts on the tick that completes the selected period. The period is 150 ms for `wd_sel_i`=000, 450 ms for 001, 1 s for 010, 5 s for 011, 10 s for 100, 20 s for 101 and 60 s for 110. The tick count is the period divided by TBASE_MS milliseconds per tick.
- R3: With `wd_sel_i`=111 the watchdog is off. Its count stays at zero and it never asserts reset.
- R4: A `wd_kick_i` pulse, or any change of `wd_sel_i`, restarts the watchdog count from zero.
- R5: A watchdog timeout asserts `cpu_rst_o` in the next cycle. Reset is held for HOLD_TICKS ticks and then released, after which the watchdog counts again from zero.
- R6: `vlow_i` high makes `cpu_rst_o` 1 one cycle later, and it stays 1 while `vlow_i` is high. Ticks seen while `vlow_i` is high do not count toward the release. After `vlow_i` falls, reset releases once HOLD_TICKS ticks have been seen.
- R7: `mem_block_o` equals `vlow_i` delayed by one clock.
- R8: `v2fail_o` equals `v2low_i` delayed by one clock, and `v2low_i` never affects `cpu_rst_o`.
- R9: `cause_o` reads 01 after a low-supply reset (rising edge of `vlow_i`) and 10 after a watchdog reset. Each new reset event overwrites the value that was there before.
- R10: A `cause_clr_i` pulse sets `cause_o` to 00 in the next cycle, unless a reset event occurs in the same cycle. In that case the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vlow_i | input | 1 | Main supply below trip level |
| v2low_i | input | 1 | Backup supply below trip level |
| wd_kick_i | input | 1 | Watchdog service strobe |
| wd_sel_i | input | 3 | Watchdog period select (111 = off) |
| tick_i | input | 1 | One-cycle pulse from the millisecond timebase |
| cause_clr_i | input | 1 | Clears the reset-cause flag |
| cpu_rst_o | output | 1 | Processor reset, active high |
| v2fail_o | output | 1 | Backup supply failure |
| mem_block_o | output | 1 | Blocks memory access while the supply is low |
| cause_o | output | 2 | Last reset cause: 00 none, 01 low supply, 10 watchdog |

## Verification
The assertions check the following on every cycle: the one-cycle delay of the low-supply and backup-supply flags onto reset, the memory block and the failure output, and the rule that reset only releases on a tick while the supply is good. They also check that the cause flag never holds both codes at once, that a clear strobe with no competing event empties the flag, and that the off setting never produces a timeout. The exact tick count of each of the seven periods, the restart caused by a kick or a select change, the hold length, and the order in which cause values overwrite each other can only be shown by the bench's scenarios.

// File: rtl/supv_pkg.sv
// Shared types and the watchdog period table for the supervisor.
// Assumes the timebase period TBASE_MS divides the table entries sensibly.
package supv_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_LOWV = 2'b01,
        CAUSE_WDOG = 2'b10
    } cause_e;

    localparam logic [2:0] WD_SEL_OFF = 3'b111;
    localparam int unsigned WD_MAX_MS = 60000;

    // Converts a period select into timebase ticks; 0 means disabled.
    function automatic int unsigned wd_limit(input logic [2:0] sel, input int unsigned tbase);
        int unsigned ms;
        int unsigned n;
        case (sel)
            3'd0:    ms = 150;
            3'd1:    ms = 450;
            3'd2:    ms = 1000;
            3'd3:    ms = 5000;
            3'd4:    ms = 10000;
            3'd5:    ms = 20000;
            3'd6:    ms = 60000;
            default: ms = 0;
        endcase
        n = ms / tbase;
        if (n == 0 && ms != 0) n = 1;
        return n;
    endfunction

endpackage

// File: rtl/supv_wdog.sv
// Watchdog counter. Counts timebase ticks while enabled and pulses
// expire_o on the tick that completes the selected period.
// Assumes tick_i is a single-cycle pulse; the counter is held clear while disabled.
module supv_wdog #(
    parameter int unsigned TBASE_MS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic [2:0] sel_i,
    input  logic       hold_i,
    output logic       expire_o
);
    import supv_pkg::*;

    localparam int unsigned CNT_W = $clog2(WD_MAX_MS / TBASE_MS + 2);

    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       sel_q;
    logic             en;
    logic             restart;
    logic [CNT_W-1:0] last;

    // Enable, restart and terminal-count decode.
    always_comb begin
        en       = !hold_i && (sel_i != WD_SEL_OFF);
        restart  = kick_i || (sel_i != sel_q);
        last     = CNT_W'(wd_limit(sel_i, TBASE_MS) - 1);
        expire_o = en && !restart && tick_i && (cnt_q == last);
    end

    // Tick counter with clear on restart, disable or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else begin
            sel_q <= sel_i;
            if (!en || restart || expire_o) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/supv_rst_hold.sv
// Reset hold generator. Any reset source sets the output and clears the
// hold counter; once sources are gone, HOLD_TICKS ticks release it.
// Assumes wd_expire_i is a one-cycle pulse. Out of reset the output starts asserted.
module supv_rst_hold #(
    parameter int unsigned HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic vlow_i,
    input  logic wd_expire_i,
    output logic rst_o
);
    localparam int unsigned HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] hcnt_q;
    logic          rst_q;

    // Sets reset on a source and counts hold ticks toward release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= 1'b1;
            hcnt_q <= '0;
        end else if (vlow_i || wd_expire_i) begin
            rst_q  <= 1'b1;
            hcnt_q <= '0;
        end else if (rst_q && tick_i) begin
            if (hcnt_q == HW'(HOLD_TICKS - 1)) begin
                rst_q  <= 1'b0;
                hcnt_q <= '0;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    assign rst_o = rst_q;

endmodule

// File: rtl/supv_cause.sv
// Reset-cause flag. Records the latest reset event; a clear strobe empties it.
// Events beat the clear, and low supply beats a simultaneous watchdog timeout.
module supv_cause (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vlow_i,
    input  logic       wd_expire_i,
    input  logic       clr_i,
    output logic [1:0] cause_o
);
    import supv_pkg::*;

    cause_e cause_q;
    logic   vlow_q;

    // Captures the event source, or clears on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
            vlow_q  <= 1'b0;
        end else begin
            vlow_q <= vlow_i;
            if (vlow_i && !vlow_q) begin
                cause_q <= CAUSE_LOWV;
            end else if (wd_expire_i) begin
                cause_q <= CAUSE_WDOG;
            end else if (clr_i) begin
                cause_q <= CAUSE_NONE;
            end
        end
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/supv_reset_ctrl.sv
// Supervisor top: watchdog, reset hold, cause flag and registered
// supply-status outputs. Assumes comparator flags are already synchronous to clk.
module supv_reset_ctrl #(
    parameter int unsigned TBASE_MS   = 1,
    parameter int unsigned HOLD_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vlow_i,
    input  logic       v2low_i,
    input  logic       wd_kick_i,
    input  logic [2:0] wd_sel_i,
    input  logic       tick_i,
    input  logic       cause_clr_i,
    output logic       cpu_rst_o,
    output logic       v2fail_o,
    output logic       mem_block_o,
    output logic [1:0] cause_o
);
    logic wd_expire;
    logic v2fail_q;
    logic memblk_q;

    supv_wdog #(.TBASE_MS(TBASE_MS)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .kick_i   (wd_kick_i),
        .sel_i    (wd_sel_i),
        .hold_i   (cpu_rst_o || vlow_i),
        .expire_o (wd_expire)
    );

    supv_rst_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .vlow_i      (vlow_i),
        .wd_expire_i (wd_expire),
        .rst_o       (cpu_rst_o)
    );

    supv_cause u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .vlow_i      (vlow_i),
        .wd_expire_i (wd_expire),
        .clr_i       (cause_clr_i),
        .cause_o     (cause_o)
    );

    // Registers the supply-status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2fail_q <= 1'b0;
            memblk_q <= 1'b0;
        end else begin
            v2fail_q <= v2low_i;
            memblk_q <= vlow_i;
        end
    end

    assign v2fail_o    = v2fail_q;
    assign mem_block_o = memblk_q;

endmodule

// File: rtl/supv_reset_chk.sv
// Property checker for supv_reset_ctrl, attached with bind.
module supv_reset_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vlow_i,
    input logic       v2low_i,
    input logic [2:0] wd_sel_i,
    input logic       tick_i,
    input logic       cause_clr_i,
    input logic       wd_expire,
    input logic       cpu_rst_o,
    input logic       v2fail_o,
    input logic       mem_block_o,
    input logic [1:0] cause_o
);
    // R6
    lowv_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_i |=> cpu_rst_o);

    // R7
    memblk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vlow_i |=> mem_block_o);

    // R7
    memblk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vlow_i |=> !mem_block_o);

    // R8
    v2fail_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v2low_i |=> v2fail_o);

    // R8
    v2fail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v2low_i |=> !v2fail_o);

    // R5
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_o) |-> ($past(tick_i) && !$past(vlow_i)));

    // R9
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));

    // R10
    cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr_i && !vlow_i && !wd_expire) |=> (cause_o == 2'b00));

    // R3
    off_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wd_sel_i) == 3'b111 && !$past(vlow_i) && !$past(cpu_rst_o)) |-> !cpu_rst_o);

endmodule

bind supv_reset_ctrl supv_reset_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vlow_i      (vlow_i),
    .v2low_i     (v2low_i),
    .wd_sel_i    (wd_sel_i),
    .tick_i      (tick_i),
    .cause_clr_i (cause_clr_i),
    .wd_expire   (wd_expire),
    .cpu_rst_o   (cpu_rst_o),
    .v2fail_o    (v2fail_o),
    .mem_block_o (mem_block_o),
    .cause_o     (cause_o)
);

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb;
    localparam int TB_MS = 50;
    localparam int HOLD  = 4;

    // Stimulus select and expected timeout in ticks (period ms / TB_MS).
    localparam logic [2:0] SEL_V [0:6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
    localparam int         EXP_V [0:6] = '{150/TB_MS, 450/TB_MS, 1000/TB_MS, 5000/TB_MS,
                                           10000/TB_MS, 20000/TB_MS, 60000/TB_MS};

    logic       clk = 0;
    logic       rst_n = 0;
    logic       vlow = 0, v2low = 0, kick = 0, tick = 0, clr = 0;
    logic [2:0] sel = 3'd7;
    logic       cpu_rst, v2fail, memblk;
    logic [1:0] cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    supv_reset_ctrl #(.TBASE_MS(TB_MS), .HOLD_TICKS(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .vlow_i(vlow), .v2low_i(v2low),
        .wd_kick_i(kick), .wd_sel_i(sel), .tick_i(tick), .cause_clr_i(clr),
        .cpu_rst_o(cpu_rst), .v2fail_o(v2fail), .mem_block_o(memblk), .cause_o(cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1;
        @(negedge clk) tick = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic pulse_kick();
        @(negedge clk) kick = 1;
        @(negedge clk) kick = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr = 1;
        @(negedge clk) clr = 0;
    endtask

    task automatic set_sel(input logic [2:0] s);
        @(negedge clk) sel = s;
        @(negedge clk);
    endtask

    // Counts ticks until reset asserts, up to a limit.
    task automatic ticks_to_rst(input int lim, output int n);
        n = 0;
        while (!cpu_rst && n < lim) begin
            do_tick();
            n++;
        end
    endtask

    // Counts ticks until reset releases, up to a limit.
    task automatic ticks_to_rel(input int lim, output int n);
        n = 0;
        while (cpu_rst && n < lim) begin
            do_tick();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: state while reset is held
        repeat (3) @(negedge clk);
        chk(cpu_rst == 1 && cause == 2'b00 && !v2fail && !memblk, "R1", {cause, cpu_rst}, 1);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk(cpu_rst == 1, "R1", cpu_rst, 1);
        ticks_to_rel(HOLD + 3, n);
        chk(n == HOLD, "R1", n, HOLD);

        // R2 R5 R9: walk the period table
        for (int v = 0; v < 7; v++) begin
            set_sel(SEL_V[v]);
            pulse_kick();
            ticks_to_rst(EXP_V[v] + 3, n);
            chk(n == EXP_V[v], "R2", n, EXP_V[v]);
            chk(cause == 2'b10, "R9", cause, 2);
            ticks_to_rel(HOLD + 3, n);
            chk(n == HOLD, "R5", n, HOLD);
        end

        // R5: after release the count restarts from zero (sel still 110)
        ticks(EXP_V[6] - 1);
        chk(cpu_rst == 0, "R5", cpu_rst, 0);
        do_tick();
        chk(cpu_rst == 1, "R5", cpu_rst, 1);
        ticks(HOLD);

        // R3 and R8: off setting with backup supply failing
        set_sel(3'd7);
        ticks(1300);
        chk(cpu_rst == 0, "R3", cpu_rst, 0);
        @(negedge clk) v2low = 1;
        @(negedge clk);
        chk(v2fail == 1 && cpu_rst == 0, "R8", {v2fail, cpu_rst}, 2);
        ticks(5);
        chk(cpu_rst == 0, "R8", cpu_rst, 0);
        @(negedge clk) v2low = 0;
        @(negedge clk);
        chk(v2fail == 0, "R8", v2fail, 0);

        // R4: kick restarts the count
        set_sel(3'd0);
        pulse_kick();
        ticks(EXP_V[0] - 1);
        pulse_kick();
        ticks(EXP_V[0] - 1);
        chk(cpu_rst == 0, "R4", cpu_rst, 0);
        do_tick();
        chk(cpu_rst == 1, "R4", cpu_rst, 1);
        ticks(HOLD);

        // R4: select change restarts the count
        set_sel(3'd1);
        pulse_kick();
        ticks(EXP_V[1] - 1);
        set_sel(3'd2);
        ticks(EXP_V[2] - 1);
        chk(cpu_rst == 0, "R4", cpu_rst, 0);
        do_tick();
        chk(cpu_rst == 1, "R4", cpu_rst, 1);
        ticks(HOLD);

        // R6 R7 R9: low supply
        set_sel(3'd0);
        @(negedge clk) vlow = 1;
        @(negedge clk);
        chk(cpu_rst == 1 && memblk == 1, "R6", {cpu_rst, memblk}, 3);
        chk(cause == 2'b01, "R9", cause, 1);
        ticks(HOLD + 2);
        chk(cpu_rst == 1, "R6", cpu_rst, 1);
        @(negedge clk) vlow = 0;
        @(negedge clk);
        chk(memblk == 0 && cpu_rst == 1, "R7", {memblk, cpu_rst}, 1);
        ticks_to_rel(HOLD + 3, n);
        chk(n == HOLD, "R6", n, HOLD);

        // R10: clear strobe
        pulse_clr();
        chk(cause == 2'b00, "R10", cause, 0);

        // R9: watchdog overwrites, then low supply overwrites
        pulse_kick();
        ticks_to_rst(EXP_V[0] + 3, n);
        chk(cause == 2'b10, "R9", cause, 2);
        @(negedge clk) vlow = 1;
        @(negedge clk);
        chk(cause == 2'b01, "R9", cause, 1);

        // R10: event wins over simultaneous clear (low supply edge)
        @(negedge clk) vlow = 0;
        pulse_clr();
        @(negedge clk) begin vlow = 1; clr = 1; end
        @(negedge clk) begin clr = 0; end
        chk(cause == 2'b01, "R10", cause, 1);
        @(negedge clk) vlow = 0;
        ticks(HOLD);

        // R1: synchronous reset mid-run
        @(negedge clk) rst_n = 0;
        @(negedge clk);
        chk(cpu_rst == 1 && cause == 2'b00, "R1", {cause, cpu_rst}, 1);
        @(negedge clk) rst_n = 1;

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule